// File: doc/BRIEF.md
# Power-Fail Deselect and Recovery Sequencer

This block sits between a host bus and a battery-backed static memory and decides, cycle by cycle, whether the memory may be touched at all. It watches three digitized supply flags from analog comparators: supply below the upper deselect level, supply below the lower deselect level, and supply below the battery switchover level. While any of them is set, the memory is held deselected and write-protected. Its data pins are not driven, and every host strobe is ignored. The switchover flag also routes storage power to the backup cell.

When the supply has returned, protection is not lifted at once. A recovery timer counts pulses of a millisecond timebase. Only after a full recovery interval of clean supply, about 100 ms by default, does normal access resume. Any dip back into the window during that interval starts the count again. A write that is running when protection engages is cut off. It is not resumed after recovery until the host has released its write strobe, so at most the byte being addressed is disturbed.

The comparator flags pass through a synchronizer. The memory strobes are registered, so a host strobe reaches the memory one clock later, and a comparator flag takes effect SYNC_STAGES + 1 clocks after it changes.

Top module: `pfd_sequencer`

## Requirements
- R1: Under reset and right after it, `write_protect`=1, `batt_sel`=1, `mem_ce_n`=1, `mem_we_n`=1 and `dq_drive_en`=0. Protection is released only after every flag is clear and the full recovery interval has been counted.
- R2: When any of the three supply flags is 1, `write_protect`=1, `mem_ce_n`=1, `mem_we_n`=1 and `dq_drive_en`=0 on the SYNC_STAGES+1'th rising edge after the flag is set (default 3). Host strobes have no effect during this time.
- R3: The lower-threshold flag alone, with the upper flag never seen (a fast supply fall), engages protection with the same latency as in R2.
- R4: `batt_sel` equals the switchover flag delayed by SYNC_STAGES+1 edges, independent of the other flags. It clears while protection is still held by a deselect flag.
- R5: Once all flags are clear, protection drops on the rising edge that samples the REC_TICKS'th `tick_ms` pulse counted in the recovery phase, and not before.
- R6: A flag set for even one cycle during recovery discards the ticks already counted, so a fresh REC_TICKS pulses are needed.
- R7: `tick_ms` pulses that arrive while any flag is set are not counted toward recovery.
- R8: When unprotected, the strobes are registered with one clock of latency. `mem_ce_n` is `host_ce_n`. `dq_drive_en` is 1 exactly when `host_ce_n`=0, `host_oe_n`=0 and `host_we_n`=1. `mem_we_n` is 0 when `host_ce_n`=0 and `host_we_n`=0 (once armed, see R9).
- R9: A write in progress when protection engages ends on the same edge on which `write_protect` rises. After recovery, `mem_we_n` stays 1 until `host_we_n` has been sampled high at least once while unprotected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_below_upper | input | 1 | Comparator: supply below upper deselect level |
| vcc_below_lower | input | 1 | Comparator: supply below lower deselect level |
| vcc_below_switch | input | 1 | Comparator: supply below battery switchover level |
| tick_ms | input | 1 | One-cycle timebase pulse, nominally 1 ms |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to memory, active low |
| mem_we_n | output | 1 | Gated write strobe to memory, active low |
| dq_drive_en | output | 1 | Enable for the memory data-out drivers |
| write_protect | output | 1 | 1 while the memory is deselected and protected |
| batt_sel | output | 1 | 1 selects the backup cell for storage power |

## Verification
The hardest situation to bring about is a write that is already underway when protection engages, with the host write strobe still held low through the whole recovery. It is reached by arming a write in the unprotected state, raising a comparator flag mid-write, and counting the full recovery interval without moving the host strobe. A recovery that is interrupted after half its ticks by a single-cycle dip is also reached with directed stimulus. Seeded random host strobe patterns and random dips on random flags then cover the gating, each checked against bench functions.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PS_DOWN    = 2'd0,
    PS_RECOVER = 2'd1,
    PS_RUN     = 2'd2
  } pstate_e;

  localparam int FLAG_UPPER  = 0;
  localparam int FLAG_LOWER  = 1;
  localparam int FLAG_SWITCH = 2;
  localparam int NFLAGS      = 3;
endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pfd_recovery_fsm.sv
module pfd_recovery_fsm
  import pfd_pkg::*;
#(
  parameter int REC_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic bad,
  input  logic tick,
  output logic run_d
);
  localparam int CNT_W = (REC_TICKS > 1) ? $clog2(REC_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_TICKS - 1);

  pstate_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (bad) begin
      state_d = PS_DOWN;
      cnt_d   = '0;
    end else begin
      case (state_q)
        PS_DOWN: begin
          state_d = PS_RECOVER;
          cnt_d   = '0;
        end
        PS_RECOVER: begin
          if (tick) begin
            if (cnt_q == LAST) begin
              state_d = PS_RUN;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        PS_RUN:  state_d = PS_RUN;
        default: state_d = PS_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_DOWN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_d = (state_d == PS_RUN);
  assign run_q = (state_q == PS_RUN);

  // R2
  bad_blocks_run_chk: assert property (@(posedge clk) disable iff (rst)
    bad |=> !run_q);

  // R5
  run_entry_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> ($past(tick) && $past(state_q == PS_RECOVER)));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/pfd_access_gate.sv
module pfd_access_gate (
  input  logic clk,
  input  logic rst,
  input  logic run_d,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic dq_oe
);
  logic armed_q;
  logic ce_q, we_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      ce_q    <= 1'b0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      armed_q <= run_d & (armed_q | host_we_n);
      ce_q    <= run_d & ~host_ce_n;
      we_q    <= run_d & armed_q & ~host_ce_n & ~host_we_n;
      oe_q    <= run_d & ~host_ce_n & ~host_oe_n & host_we_n;
    end
  end

  assign mem_ce_n = ~ce_q;
  assign mem_we_n = ~we_q;
  assign dq_oe    = oe_q;

  // R8
  no_drive_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> mem_we_n);

  // R8
  strobe_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n || dq_oe) |-> !mem_ce_n);
endmodule

// File: rtl/pfd_sequencer.sv
module pfd_sequencer
  import pfd_pkg::*;
#(
  parameter int REC_TICKS   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_below_upper,
  input  logic vcc_below_lower,
  input  logic vcc_below_switch,
  input  logic tick_ms,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic dq_drive_en,
  output logic write_protect,
  output logic batt_sel
);
  logic [NFLAGS-1:0] raw_flags, s_flags;
  logic              bad, run_d;
  logic              prot_q, batt_q;

  always_comb begin
    raw_flags              = '0;
    raw_flags[FLAG_UPPER]  = vcc_below_upper;
    raw_flags[FLAG_LOWER]  = vcc_below_lower;
    raw_flags[FLAG_SWITCH] = vcc_below_switch;
  end

  pfd_sync #(
    .W(NFLAGS), .STAGES(SYNC_STAGES), .RST_VAL({NFLAGS{1'b1}})
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_flags), .q(s_flags)
  );

  assign bad = |s_flags;

  pfd_recovery_fsm #(.REC_TICKS(REC_TICKS)) u_fsm (
    .clk(clk), .rst(rst), .bad(bad), .tick(tick_ms), .run_d(run_d)
  );

  pfd_access_gate u_gate (
    .clk(clk), .rst(rst), .run_d(run_d),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .dq_oe(dq_drive_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= 1'b1;
      batt_q <= 1'b1;
    end else begin
      prot_q <= ~run_d;
      batt_q <= s_flags[FLAG_SWITCH];
    end
  end

  assign write_protect = prot_q;
  assign batt_sel      = batt_q;

  // R4
  batt_implies_prot_chk: assert property (@(posedge clk) disable iff (rst)
    batt_sel |-> write_protect);

  // R2
  select_only_unprot_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !write_protect);

  // R9
  write_cut_with_prot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(write_protect) |-> (mem_we_n && !dq_drive_en));
endmodule

// File: tb/tb_pfd_sequencer.sv
`timescale 1ns/1ps
module tb_pfd_sequencer;
  localparam int REC = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b1, lo = 1'b1, sw = 1'b1, tick = 1'b0;
  logic ce = 1'b1, we = 1'b1, oe = 1'b1;
  logic mce, mwe, dqe, prot, batt;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;
  bit   armed_b;
  int   seed_dummy;

  always #10 clk = ~clk;

  pfd_sequencer #(.REC_TICKS(REC), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .vcc_below_upper(up), .vcc_below_lower(lo),
    .vcc_below_switch(sw), .tick_ms(tick), .host_ce_n(ce), .host_we_n(we),
    .host_oe_n(oe), .mem_ce_n(mce), .mem_we_n(mwe), .dq_drive_en(dqe),
    .write_protect(prot), .batt_sel(batt)
  );

  function automatic logic exp_we_n(bit armed, logic c, logic w);
    return !(armed && !c && !w);
  endfunction
  function automatic logic exp_dq(logic c, logic w, logic o);
    return !c && !o && w;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_protected(input string tag);
    chk({tag, " protect"}, prot, 1'b1);
    chk({tag, " ce_n"}, mce, 1'b1);
    chk({tag, " we_n"}, mwe, 1'b1);
    chk({tag, " dq"}, dqe, 1'b0);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  // clear flags already done by caller; count a full recovery
  task automatic recover_full(input string tag);
    wait_n(4);
    for (int i = 0; i < REC - 1; i++) pulse_tick();
    chk({tag, " still protected before last tick"}, prot, 1'b1);
    pulse_tick();
    chk({tag, " released on last tick"}, prot, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    seed_dummy = $urandom(32'h1F2E3D4C);
    wait_n(5);
    // R1 reset state
    chk_protected("R1 in reset");
    chk("R1 batt in reset", batt, 1'b1);
    rst = 1'b0;
    wait_n(1);
    chk_protected("R1 after reset");
    chk("R1 batt after reset", batt, 1'b1);

    // R2 host strobes ignored while flags set
    ce = 1'b0; we = 1'b0; oe = 1'b0;
    wait_n(4);
    chk_protected("R2 host ignored");

    // R7 ticks while bad are not counted
    sw = 1'b0;
    for (int i = 0; i < REC; i++) pulse_tick();
    chk("R7 protect after bad ticks", prot, 1'b1);
    chk("R4 batt cleared with deselect still held", batt, 1'b0);
    up = 1'b0; lo = 1'b0;
    // R1 / R5: full recovery needed, host still holding write low
    recover_full("R5");
    // R9 write not resumed: we held low through recovery
    chk("R9 write held off after recovery", mwe, 1'b1);
    chk("R8 ce passes", mce, 1'b0);
    chk("R8 no drive while we low", dqe, 1'b0);

    // R8 read then write
    we = 1'b1;
    wait_n(1);
    chk("R8 read drive", dqe, 1'b1);
    chk("R8 we_n idle on read", mwe, 1'b1);
    we = 1'b0;
    wait_n(1);
    chk("R8 write strobe", mwe, 1'b0);
    chk("R8 drive off in write", dqe, 1'b0);

    // R9 / R2 abort a write in progress
    up = 1'b1;
    wait_n(2);
    chk("R2 latency not yet", mwe, 1'b0);
    wait_n(1);
    chk("R9 write cut", mwe, 1'b1);
    chk_protected("R2 upper flag");

    // R6 restart on dip during recovery, R3 lower-only dip
    up = 1'b0;
    wait_n(4);
    for (int i = 0; i < REC / 2; i++) pulse_tick();
    lo = 1'b1;
    wait_n(1);
    lo = 1'b0;
    recover_full("R6");

    // R3 fast fall: lower flag only
    we = 1'b1; ce = 1'b0; oe = 1'b0;
    wait_n(1);
    lo = 1'b1;
    wait_n(2);
    chk("R3 not yet", prot, 1'b0);
    wait_n(1);
    chk_protected("R3 lower only");

    // R4 switchover independent of deselect flags
    sw = 1'b1;
    wait_n(2);
    chk("R4 batt latency", batt, 1'b0);
    wait_n(1);
    chk("R4 batt set", batt, 1'b1);
    sw = 1'b0;
    wait_n(3);
    chk("R4 batt cleared", batt, 1'b0);
    chk("R4 still protected", prot, 1'b1);
    lo = 1'b0;
    recover_full("R5 second");
    armed_b = (we == 1'b1);

    // random phase
    for (int round = 0; round < 3; round++) begin
      for (int s = 0; s < 150; s++) begin
        bit a0;
        ce = 1'($urandom() & 1);
        we = 1'($urandom() & 1);
        oe = 1'($urandom() & 1);
        a0 = armed_b;
        wait_n(1);
        chk("R8 rnd ce", mce, ce);
        chk("R8 rnd dq", dqe, exp_dq(ce, we, oe));
        chk("R9 rnd we", mwe, exp_we_n(a0, ce, we));
        armed_b = armed_b | we;
      end
      begin
        int f;
        f = int'($urandom() % 3);
        if (f == 0) up = 1'b1; else if (f == 1) lo = 1'b1; else sw = 1'b1;
        wait_n(3);
        chk_protected("R2 rnd dip");
        up = 1'b0; lo = 1'b0; sw = 1'b0;
        recover_full("R5 rnd");
        armed_b = (we == 1'b1);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule